// File: doc/BRIEF.md
# Descriptor Hit Statistics Counter

This block is one statistics unit that sits beside an address-decode fabric. Every clock cycle the fabric presents two vectors of hit strobes, one for memory descriptors and one for I/O descriptors. A mask selects which of those strobes the unit watches. If any watched strobe is high in a cycle, that cycle carries one hit event, no matter how many strobes are high.

The unit keeps a live count and a load value. An 8-bit action word decides what a hit event does and what a zero count does. A hit event can load the count or decrement it. The count can also decrement on every cycle. A zero count can trigger a reload. A hit or a zero count can raise a sticky request flag and a sticky error flag. Software uses a plain write port with four addresses. The read port is combinational.

Top module: `hitstat_unit`

## Requirements
- R1: After reset, every register reads zero, `reqOut` is low and `errOut` is low. The registers are the count, the load value, both masks, the action word and both flags.
- R2: A write to address 0 sets the load value from the upper half of the data word and the count from the lower half. Address 1 holds the I/O mask in the upper half and the memory mask in the lower half; mask bits beyond the number of strobes read as zero. Address 2 holds the action word in bits 7:0. Address 3 reads the request flag in bit 0 and the error flag in bit 1. Each address reads back in the same layout.
- R3: When action bit 0 is set, a hit event copies the load value into the count on the next cycle.
- R4: When action bit 1 is set, a hit event lowers the count by one.
- R5: When action bit 4 is set, the count drops by one on every cycle.
- R6: When a load and a decrement fall in the same cycle, the load wins and the count takes the load value exactly.
- R7: When action bit 7 is clear, a zero count stays at zero. It never wraps to all ones.
- R8: When action bit 7 is set, a count of zero is replaced by the load value on the next cycle.
- R9: A strobe whose mask bit is clear has no effect. Several watched strobes in one cycle count as one event.
- R10: The request flag sets on a hit event when action bit 2 is set, or on a zero count when action bit 5 is set. Once set, it stays set.
- R11: The error flag sets on a hit event when action bit 3 is set, or on a zero count when action bit 6 is set. Once set, it stays set.
- R12: Writing a one to bit 0 of address 3 clears the request flag, and a one in bit 1 clears the error flag. If a set condition is present in the same cycle, the set wins.
- R13: A write to address 0 replaces the count, and it overrides any load or decrement in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memHit | input | N_MEM | Memory-descriptor hit strobes |
| ioHit | input | N_IO | I/O-descriptor hit strobes |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 count/load, 1 mask, 2 action, 3 status) |
| regWrData | input | 2*HALF_W | Write data |
| regRdData | output | 2*HALF_W | Combinational read data for `regAddr` |
| reqOut | output | 1 | Sticky request flag |
| errOut | output | 1 | Sticky error flag |

## Verification
The bench builds the unit with an 8-bit half word, four memory strobes and three I/O strobes. With only seven strobes, the bench can drive all 128 hit patterns against sixteen different mask pairs, which covers the masking and single-event rules in full. The 8-bit count also makes it cheap to walk the count through zero, through saturation and through the reload sequence, with the expected values computed arithmetically.

// File: rtl/hitstat_pkg.sv
package hitstat_pkg;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_MASK   = 2'd1,
    REG_ACTION = 2'd2,
    REG_STATUS = 2'd3
  } regSel_e;

  localparam int ACT_W = 8;

  // action word bit positions
  localparam int A_LOAD_HIT = 0;
  localparam int A_DEC_HIT  = 1;
  localparam int A_REQ_HIT  = 2;
  localparam int A_ERR_HIT  = 3;
  localparam int A_DEC_FREE = 4;
  localparam int A_REQ_ZERO = 5;
  localparam int A_ERR_ZERO = 6;
  localparam int A_RELOAD   = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCount;
    logic loadCnt;
    logic decCnt;
    logic setReq;
    logic setErr;
    logic clrReq;
    logic clrErr;
  } ctrlStrobe_t;

endpackage

// File: rtl/hitstat_ctrl.sv
module hitstat_ctrl
  import hitstat_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int N_MEM  = 32,
  parameter int N_IO   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N_MEM-1:0]      memHit,
  input  logic [N_IO-1:0]       ioHit,
  input  logic                  regWrEn,
  input  logic [1:0]            regAddr,
  input  logic [2*HALF_W-1:0]   regWrData,
  input  logic                  cntZero,
  output ctrlStrobe_t           strb,
  output logic [N_MEM-1:0]      memMask,
  output logic [N_IO-1:0]       ioMask,
  output logic [ACT_W-1:0]      action
);

  logic hitEvt;
  logic wrCnt;
  logic loadReq;
  logic decReq;

  // any watched strobe forms one event
  assign hitEvt = (|(memHit & memMask)) | (|(ioHit & ioMask));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memMask <= '0;
      ioMask  <= '0;
      action  <= '0;
    end else if (regWrEn) begin
      if (regAddr == REG_MASK) begin
        memMask <= regWrData[N_MEM-1:0];
        ioMask  <= regWrData[HALF_W +: N_IO];
      end
      if (regAddr == REG_ACTION) begin
        action <= regWrData[ACT_W-1:0];
      end
    end
  end

  always_comb begin
    wrCnt   = regWrEn && (regAddr == REG_COUNT);
    loadReq = (action[A_LOAD_HIT] && hitEvt) || (action[A_RELOAD] && cntZero);
    decReq  = (action[A_DEC_HIT] && hitEvt) || action[A_DEC_FREE];

    strb.wrCount = wrCnt;
    strb.loadCnt = loadReq && !wrCnt;
    strb.decCnt  = decReq && !loadReq && !cntZero && !wrCnt;
    strb.setReq  = (action[A_REQ_HIT] && hitEvt) || (action[A_REQ_ZERO] && cntZero);
    strb.setErr  = (action[A_ERR_HIT] && hitEvt) || (action[A_ERR_ZERO] && cntZero);
    strb.clrReq  = regWrEn && (regAddr == REG_STATUS) && regWrData[0];
    strb.clrErr  = regWrEn && (regAddr == REG_STATUS) && regWrData[1];
  end

  // R5: free-running mode always moves a nonzero count unless software writes it
  a_r5_free_moves: assert property (@(posedge clk) disable iff (!rstN)
    (action[A_DEC_FREE] && !cntZero && !(regWrEn && regAddr == REG_COUNT))
      |-> (strb.loadCnt || strb.decCnt));

  // R9: with no watched strobe and no hit-independent action, nothing happens
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (((memHit & memMask) == '0) && ((ioHit & ioMask) == '0) && (action[7:4] == 4'd0))
      |-> !(strb.loadCnt || strb.decCnt || strb.setReq || strb.setErr));

endmodule

// File: rtl/hitstat_dp.sv
module hitstat_dp
  import hitstat_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [2*HALF_W-1:0]   regWrData,
  output logic [HALF_W-1:0]     count,
  output logic [HALF_W-1:0]     loadVal,
  output logic                  cntZero,
  output logic                  reqFlag,
  output logic                  errFlag
);

  localparam logic [HALF_W-1:0] CNT_ONE = HALF_W'(1);

  assign cntZero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      loadVal <= '0;
    end else if (strb.wrCount) begin
      loadVal <= regWrData[2*HALF_W-1:HALF_W];
      count   <= regWrData[HALF_W-1:0];
    end else if (strb.loadCnt) begin
      count <= loadVal;
    end else if (strb.decCnt) begin
      count <= count - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqFlag <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      reqFlag <= strb.setReq | (reqFlag & ~strb.clrReq);
      errFlag <= strb.setErr | (errFlag & ~strb.clrErr);
    end
  end

  // R3 / R8: a load strobe delivers the load value
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCnt && !strb.wrCount) |=> (count == $past(loadVal)));

  // R4: one decrement strobe lowers the count by exactly one
  a_r4_dec_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decCnt && !strb.loadCnt && !strb.wrCount) |=> (count == $past(count) - CNT_ONE));

  // R7: zero holds unless loaded or written
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !strb.loadCnt && !strb.wrCount) |=> (count == '0));

  // R10: request flag is sticky
  a_r10_req_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (reqFlag && !strb.clrReq) |=> reqFlag);

  // R11: error flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strb.clrErr) |=> errFlag);

  // R12: set beats clear, clear alone empties the flag
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setReq |=> reqFlag);
  a_r12_clear_req: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrReq && !strb.setReq) |=> !reqFlag);

endmodule

// File: rtl/hitstat_unit.sv
module hitstat_unit
  import hitstat_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int N_MEM  = 32,
  parameter int N_IO   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N_MEM-1:0]      memHit,
  input  logic [N_IO-1:0]       ioHit,
  input  logic                  regWrEn,
  input  logic [1:0]            regAddr,
  input  logic [2*HALF_W-1:0]   regWrData,
  output logic [2*HALF_W-1:0]   regRdData,
  output logic                  reqOut,
  output logic                  errOut
);

  localparam int DATA_W = 2 * HALF_W;

  ctrlStrobe_t          strb;
  logic [N_MEM-1:0]     memMask;
  logic [N_IO-1:0]      ioMask;
  logic [ACT_W-1:0]     action;
  logic [HALF_W-1:0]    count;
  logic [HALF_W-1:0]    loadVal;
  logic                 cntZero;
  logic                 reqFlag;
  logic                 errFlag;
  logic [HALF_W-1:0]    memMaskWide;
  logic [HALF_W-1:0]    ioMaskWide;

  hitstat_ctrl #(.HALF_W(HALF_W), .N_MEM(N_MEM), .N_IO(N_IO)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .memHit    (memHit),
    .ioHit     (ioHit),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .cntZero   (cntZero),
    .strb      (strb),
    .memMask   (memMask),
    .ioMask    (ioMask),
    .action    (action)
  );

  hitstat_dp #(.HALF_W(HALF_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .count     (count),
    .loadVal   (loadVal),
    .cntZero   (cntZero),
    .reqFlag   (reqFlag),
    .errFlag   (errFlag)
  );

  assign memMaskWide = HALF_W'(memMask);
  assign ioMaskWide  = HALF_W'(ioMask);

  always_comb begin
    case (regAddr)
      REG_COUNT:  regRdData = {loadVal, count};
      REG_MASK:   regRdData = {ioMaskWide, memMaskWide};
      REG_ACTION: regRdData = DATA_W'(action);
      default:    regRdData = DATA_W'({errFlag, reqFlag});
    endcase
  end

  assign reqOut = reqFlag;
  assign errOut = errFlag;

endmodule

// File: tb/hitstat_unit_test.sv
module hitstat_unit_test;
  localparam int HW = 8;
  localparam int NM = 4;
  localparam int NI = 3;
  localparam int DW = 2 * HW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NM-1:0] memHit = '0;
  logic [NI-1:0] ioHit = '0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic          reqOut;
  logic          errOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hitstat_unit #(.HALF_W(HW), .N_MEM(NM), .N_IO(NI)) uut (
    .clk(clk), .rstN(rstN), .memHit(memHit), .ioHit(ioHit),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .reqOut(reqOut), .errOut(errOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic hitPulse(input logic [NM-1:0] m, input logic [NI-1:0] i);
    @(negedge clk);
    memHit = m; ioHit = i;
    @(negedge clk);
    memHit = '0; ioHit = '0;
  endtask

  function automatic logic [7:0] lowByte(input logic [DW-1:0] d);
    return d[7:0];
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reset reg", d, 0);
    end
    check("R1 reset reqOut", reqOut, 0);
    check("R1 reset errOut", errOut, 0);

    // R2 register layout
    wr(2'd0, 16'hA7C3); rd(2'd0, d); check("R2 count/load", d, 16'hA7C3);
    wr(2'd1, 16'hFFFF); rd(2'd1, d); check("R2 mask", d, 16'h070F);
    wr(2'd2, 16'h5A21); rd(2'd2, d); check("R2 action", d, 16'h0021);
    wr(2'd2, 16'h0000);
    rd(2'd0, d); check("R2 count untouched", d, 16'hA7C3);
    rd(2'd3, d); check("R2 status", d, 0);

    // R4 / R9 sweep: decrement on hit over masks and all hit patterns
    wr(2'd2, 16'h0002);
    for (int mi = 0; mi < 16; mi++) begin
      logic [2:0] ioM;
      ioM = mi[2:0] ^ 3'b101;
      wr(2'd1, {5'b0, ioM, 4'b0, mi[3:0]});
      wr(2'd0, 16'h00FF);
      exp = 255;
      for (int h = 0; h < 128; h++) begin
        hitPulse(h[3:0], h[6:4]);
        if (((h[3:0] & mi[3:0]) != 0) || ((h[6:4] & ioM) != 0)) exp--;
        rd(2'd0, d);
        check("R9/R4 masked dec", lowByte(d), exp[7:0]);
      end
    end

    // R3 load on hit
    wr(2'd1, 16'h070F);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h4010);
    repeat (2) @(negedge clk);
    rd(2'd0, d); check("R3 no hit no load", lowByte(d), 8'h10);
    hitPulse(4'b0001, 3'b000);
    rd(2'd0, d); check("R3 load mem hit", lowByte(d), 8'h40);
    wr(2'd0, 16'h4010);
    hitPulse(4'b0000, 3'b100);
    rd(2'd0, d); check("R3 load io hit", lowByte(d), 8'h40);

    // R6 load priority
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h4010);
    hitPulse(4'b0010, 3'b000);
    rd(2'd0, d); check("R6 load beats hit dec", lowByte(d), 8'h40);
    wr(2'd2, 16'h0013);
    wr(2'd0, 16'h4010);
    hitPulse(4'b0010, 3'b000);
    rd(2'd0, d); check("R6 load beats free dec", lowByte(d), 8'h40);

    // R5 / R7 free-running decrement, saturation
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h000A);
    wr(2'd2, 16'h0010);
    for (int k = 0; k < 15; k++) begin
      rd(2'd0, d);
      check("R5/R7 free dec", lowByte(d), (k < 10) ? (10 - k) : 0);
      @(negedge clk);
    end

    // R13 write overrides decrement
    wr(2'd0, 16'h0033);
    rd(2'd0, d); check("R13 write wins", lowByte(d), 8'h33);
    @(negedge clk);
    rd(2'd0, d); check("R5 after write", lowByte(d), 8'h32);

    // R8 reload at zero
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0502);
    wr(2'd2, 16'h0090);
    exp = 2;
    for (int k = 0; k < 20; k++) begin
      rd(2'd0, d);
      check("R8 reload", lowByte(d), exp[7:0]);
      exp = (exp == 0) ? 5 : exp - 1;
      @(negedge clk);
    end

    // R10 / R11 / R12 flags on hit
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0003);
    check("R12 cleared", reqOut, 0);
    wr(2'd0, 16'h0050);
    wr(2'd2, 16'h0004);
    hitPulse(4'b0001, 3'b000);
    check("R10 req on hit", reqOut, 1);
    check("R11 no err", errOut, 0);
    repeat (3) @(negedge clk);
    check("R10 sticky", reqOut, 1);
    wr(2'd3, 16'h0001);
    check("R12 w1c req", reqOut, 0);
    rd(2'd3, d); check("R12 status empty", d, 0);
    wr(2'd2, 16'h0008);
    hitPulse(4'b0000, 3'b001);
    check("R11 err on hit", errOut, 1);
    check("R10 no req", reqOut, 0);
    rd(2'd3, d); check("R11 status", d, 2);
    wr(2'd3, 16'h0002);
    check("R12 w1c err", errOut, 0);

    // zero-count events
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0020);
    @(negedge clk);
    check("R10 req on zero", reqOut, 1);
    wr(2'd3, 16'h0001);
    check("R12 set wins", reqOut, 1);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0001);
    check("R12 clear after", reqOut, 0);
    wr(2'd2, 16'h0040);
    @(negedge clk);
    check("R11 err on zero", errOut, 1);
    check("R11 req idle", reqOut, 0);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0002);
    check("R12 err cleared", errOut, 0);

    // R9 zero mask ignores strobes
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0005);
    wr(2'd0, 16'h4010);
    hitPulse(4'b1111, 3'b111);
    rd(2'd0, d); check("R9 unmasked ignored", lowByte(d), 8'h10);
    check("R9 no req", reqOut, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule